// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits in the fetch stage of a small 64-bit processor. Each cycle it takes the current fetch address, a ten-byte window read from instruction memory at that address (byte 0 in the low eight bits), and a flag from that memory that reports an out-of-range fetch. It splits the first byte into an instruction code and a function code. It works out from the instruction code whether a register-specifier byte and an eight-byte little-endian constant follow, and from that the instruction length. It then extracts the operand fields and produces the sequential next address, a predicted next address and a fetch status.

The decode is purely combinational. A single register holds the predicted address for the next cycle. It reloads on every clock and restarts from a parameterised reset address.

Top module: `fetch_decode`

## Requirements
- R1: `icode` equals bits 7:4 of byte 0 and `ifun` equals bits 3:0 of byte 0.
- R2: A register byte follows byte 0 for instruction codes 2, 3, 4, 5, 6, 0xA and 0xB. In that case `ra` is bits 7:4 of byte 1 and `rb` is bits 3:0 of byte 1. For every other code both report 0xF.
- R3: An eight-byte little-endian constant is present for codes 3, 4, 5, 7 and 8. It starts at byte 2 when a register byte is present and at byte 1 otherwise. When no constant is present, `valc` is zero.
- R4: `valp` equals `pc` plus the length, where the length is 1, plus 1 for a register byte, plus 8 for a constant. Codes 0xC to 0xF have length 1.
- R5: The only legal pairs are the following. Codes 0, 1, 3, 4, 5, 8, 9, 0xA and 0xB are legal only with function 0. Codes 2 and 7 are legal with functions 0 to 6. Code 6 is legal with functions 0 to 3. Any other pair gives status 4 (invalid instruction).
- R6: Byte 0 equal to 0x00 gives status 2 (halted).
- R7: When `imem_err` is high, the status is 3 (address error), whatever the bytes contain.
- R8: A legal, non-halt instruction with no memory error gives status 1 (normal).
- R9: `pred_pc` equals `valc` for codes 7 and 8, and equals `valp` for every other code.
- R10: `held_pc` equals `RESET_PC` while `rst_n` is low. After each rising clock edge with reset released, it equals the `pred_pc` present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | 64 | Address of the instruction being fetched |
| ibytes | input | 80 | Ten instruction bytes, byte 0 in bits 7:0 |
| imem_err | input | 1 | Instruction memory reports an invalid fetch address |
| icode | output | 4 | Instruction code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register specifier, 0xF when absent |
| rb | output | 4 | Second register specifier, 0xF when absent |
| valc | output | 64 | Constant word, zero when absent |
| valp | output | 64 | Address of the next sequential instruction |
| pred_pc | output | 64 | Predicted next fetch address |
| stat | output | 3 | 1 normal, 2 halted, 3 address error, 4 invalid |
| held_pc | output | 64 | Registered predicted address |

## Verification
The constant offset is the main target. Jump and call place the constant at byte 1, while store, load and immediate move place it at byte 2. A decoder that used one fixed offset would return a constant shifted by one byte for one of the two groups. Every one of the 256 code/function pairs is compared against an independent length and legality model. This catches a legality range that is off by one, such as accepting function 7 for conditional moves or function 4 for integer ops. It also catches an unknown code that is given a non-unit length. The bench drives a halt byte and an illegal byte while `imem_err` is high, to expose a status priority that lets either one mask the address error. It also checks the worked store example byte by byte.

// File: rtl/fetch_decode.sv
`timescale 1ns/1ps
module fetch_decode #(
  parameter logic [63:0] RESET_PC = 64'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] pc,
  input  logic [79:0] ibytes,
  input  logic        imem_err,
  output logic [3:0]  icode,
  output logic [3:0]  ifun,
  output logic [3:0]  ra,
  output logic [3:0]  rb,
  output logic [63:0] valc,
  output logic [63:0] valp,
  output logic [63:0] pred_pc,
  output logic [2:0]  stat,
  output logic [63:0] held_pc
);
  localparam logic [2:0] ST_OK = 3'd1, ST_HLT = 3'd2, ST_ADR = 3'd3, ST_INS = 3'd4;

  logic has_reg, has_const, legal;
  logic [3:0] len;

  assign icode = ibytes[7:4];
  assign ifun  = ibytes[3:0];

  always_comb begin
    has_reg   = 1'b0;
    has_const = 1'b0;
    legal     = 1'b0;
    case (icode)
      4'h0, 4'h1, 4'h9: legal = (ifun == 4'h0);
      4'h2: begin has_reg = 1'b1; legal = (ifun <= 4'h6); end
      4'h3, 4'h4, 4'h5: begin has_reg = 1'b1; has_const = 1'b1; legal = (ifun == 4'h0); end
      4'h6: begin has_reg = 1'b1; legal = (ifun <= 4'h3); end
      4'h7: begin has_const = 1'b1; legal = (ifun <= 4'h6); end
      4'h8: begin has_const = 1'b1; legal = (ifun == 4'h0); end
      4'hA, 4'hB: begin has_reg = 1'b1; legal = (ifun == 4'h0); end
      default: ;
    endcase
  end

  assign ra   = has_reg ? ibytes[15:12] : 4'hF;
  assign rb   = has_reg ? ibytes[11:8]  : 4'hF;
  assign valc = !has_const ? 64'd0 : (has_reg ? ibytes[79:16] : ibytes[71:8]);
  assign len  = 4'd1 + {3'd0, has_reg} + {has_const, 3'd0};
  assign valp = pc + {60'd0, len};
  assign pred_pc = (icode == 4'h7 || icode == 4'h8) ? valc : valp;

  assign stat = imem_err ? ST_ADR :
                !legal   ? ST_INS :
                (icode == 4'h0) ? ST_HLT : ST_OK;

  always_ff @(posedge clk) begin
    if (!rst_n) held_pc <= RESET_PC;
    else        held_pc <= pred_pc;
  end

  // R2
  reg_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valp == pc + 64'd1 || valp == pc + 64'd9) |-> (ra == 4'hF && rb == 4'hF));
  // R4
  length_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valp - pc == 64'd1) || (valp - pc == 64'd2) || (valp - pc == 64'd9) || (valp - pc == 64'd10));
  // R6
  halt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 3'd2) |-> (icode == 4'h0 && ifun == 4'h0 && !imem_err));
  // R7
  adr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_err |-> (stat == 3'd3));
  // R9
  branch_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (icode == 4'h7 || icode == 4'h8) |-> (pred_pc == valc && valp == pc + 64'd9));
  // R10
  held_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (held_pc == $past(pred_pc)));
endmodule

// File: tb/tb_fetch_decode.sv
`timescale 1ns/1ps
module tb_fetch_decode;
  localparam logic [63:0] RST_ADDR = 64'h0000_0000_0000_0F00;
  localparam int NV = 8;
  // entry: {ibytes, pc, stat, valp, pred}
  localparam logic [274:0] TV [NV] = '{
    {80'h00000000000000000010, 64'h100, 3'd1, 64'h101, 64'h101},
    {80'h00000000000000002360, 64'h200, 3'd1, 64'h202, 64'h202},
    {80'h00000000000000123470, 64'h010, 3'd1, 64'h019, 64'h1234},
    {80'h00000000000000004080, 64'h000, 3'd1, 64'h009, 64'h040},
    {80'h00000000000000000127, 64'h300, 3'd4, 64'h302, 64'h302},
    {80'h0000000000000005F330, 64'h008, 3'd1, 64'h012, 64'h012},
    {80'h00000000000000000090, 64'h050, 3'd1, 64'h051, 64'h051},
    {80'h000000000000000000C0, 64'h060, 3'd4, 64'h061, 64'h061}
  };

  logic clk = 0, rst_n = 0, imem_err = 0;
  logic [63:0] pc = 0;
  logic [79:0] ibytes = 0;
  logic [3:0] icode, ifun, ra, rb;
  logic [63:0] valc, valp, pred_pc, held_pc;
  logic [2:0] stat;
  int checks = 0, errors = 0;
  logic done = 0;

  always #10 clk = ~clk;

  fetch_decode #(.RESET_PC(RST_ADDR)) dut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .ibytes(ibytes), .imem_err(imem_err),
    .icode(icode), .ifun(ifun), .ra(ra), .rb(rb), .valc(valc), .valp(valp),
    .pred_pc(pred_pc), .stat(stat), .held_pc(held_pc));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 chk("R10 reset", held_pc, RST_ADDR);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ibytes = TV[i][274:195]; pc = TV[i][194:131];
      #5;
      chk("R5/R8 table stat", {61'd0, stat}, {61'd0, TV[i][130:128]});
      chk("R4 table valp", valp, TV[i][127:64]);
      chk("R9 table pred", pred_pc, TV[i][63:0]);
      @(posedge clk); #1;
      chk("R10 held", held_pc, TV[i][63:0]);
    end

    for (int p = 0; p < 256; p++) begin
      logic [3:0] c, f;
      logic er, ec, lg;
      logic [3:0] ln;
      logic [63:0] xc;
      @(negedge clk);
      c = p[7:4]; f = p[3:0];
      ibytes = {72'h9988776655443322A7, c, f};
      pc = 64'h1000 + 64'(p);
      er = (c inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB});
      ec = (c inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8});
      lg = (c == 4'h2 || c == 4'h7) ? (f <= 4'h6) :
           (c == 4'h6) ? (f <= 4'h3) : (c <= 4'hB && f == 4'h0);
      ln = 4'd1 + (er ? 4'd1 : 4'd0) + (ec ? 4'd8 : 4'd0);
      xc = !ec ? 64'd0 : (er ? 64'h9988776655443322 : 64'h88776655443322A7);
      #5;
      chk("R1 icode/ifun", {56'd0, icode, ifun}, {56'd0, c, f});
      chk("R2 regs", {56'd0, ra, rb}, er ? 64'hA7 : 64'hFF);
      chk("R3 const", valc, xc);
      chk("R4 valp", valp, pc + 64'(ln));
      chk("R5/R6/R8 stat", {61'd0, stat},
          !lg ? 64'd4 : (c == 4'h0 ? 64'd2 : 64'd1));
      chk("R9 pred", pred_pc, (c == 4'h7 || c == 4'h8) ? xc : pc + 64'(ln));
    end

    @(negedge clk);
    ibytes = 80'h00_01_23_45_67_89_ab_cd_42_40; pc = 64'h40; #5;
    chk("R2 store ra", {60'd0, ra}, 64'h4);
    chk("R2 store rb", {60'd0, rb}, 64'h2);
    chk("R3 store const", valc, 64'h0001_2345_6789_abcd);
    chk("R4 store valp", valp, 64'h4A);

    @(negedge clk);
    ibytes = 80'h0; imem_err = 1; #5;
    chk("R7 over halt", {61'd0, stat}, 64'd3);
    @(negedge clk);
    ibytes = 80'h000000000000000000F5; #5;
    chk("R7 over invalid", {61'd0, stat}, 64'd3);
    @(negedge clk);
    imem_err = 0; ibytes = 80'h0; #5;
    chk("R6 halt", {61'd0, stat}, 64'd2);
    chk("R4 halt valp", valp, 64'h41);

    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    chk("R10 re-reset", held_pc, RST_ADDR);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule